// File: doc/BRIEF.md
# Pointer-Based Address Generation Unit

This unit forms 24-bit byte addresses for a processor whose datapath is 16 bits wide. It holds four pointer registers: program counter, stack pointer, frame pointer and base pointer. Each pointer is kept as a 16-bit low word and an 8-bit upper byte, and either half can be loaded on its own. When a request arrives, a base is taken from one of the pointers or from a 16-bit general register value supplied from outside, which is zero-extended. A 16-bit extension word, read as two's complement, is sign-extended and added to the base by a 24-bit carry look-ahead adder. The chosen result is latched into an address buffer register.

Five addressing modes are provided. Immediate forwards the extension word as a literal. Direct uses the base unchanged. Indexed adds the offset to the base. Pre-increment and post-increment also write the updated value back into the selected pointer. An error flag reports odd addresses on word accesses. The decoder drives the request fields, and the memory bus reads the buffer one cycle after each request.

Top module: `addr_gen_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all four pointers, `addr_buf`, `addr_valid` and `misalign` are cleared to zero.
- R2: `ptr_ld_lo` writes `ptr_ld_data` into bits 15:0 of pointer `ptr_ld_idx`, and `ptr_ld_hi` writes `ptr_ld_data[7:0]` into bits 23:16. The half that is not loaded keeps its value. Pointer index 0 is PC, 1 is SP, 2 is FP and 3 is BP. Pointer i appears on `ptr_q[24*i+23:24*i]` one cycle after the edge that loads it.
- R3: Mode 0 (immediate) puts the sign-extended `ext_word` into `addr_buf`. It writes back nothing and never raises `misalign`.
- R4: Mode 1 (direct) puts the base into `addr_buf`, and `ext_word` has no effect. The base is pointer `ptr_idx` when `src_is_ptr` is 1, and otherwise `gpr_val` zero-extended.
- R5: Mode 2 (indexed) puts base + sign-extended `ext_word` into `addr_buf` and leaves every pointer unchanged.
- R6: Mode 3 (pre-increment) with a pointer base puts base + offset into both `addr_buf` and the selected pointer.
- R7: Mode 4 (post-increment) with a pointer base puts the unmodified base into `addr_buf` and base + offset into the selected pointer.
- R8: In modes 3 and 4 with a general register base (`src_is_ptr` = 0), no pointer changes.
- R9: If a load and a write-back hit the same pointer in the same cycle, each loaded half takes the load data. Each half that is not loaded takes the write-back value.
- R10: Modes 5 to 7 are reserved. They leave `addr_buf` and all pointers unchanged, and `addr_valid` is low in the next cycle.
- R11: `misalign` is high in the cycle after a request in modes 1 to 4 with `word_acc` = 1 whose resulting address has bit 0 set. It is low in every other case.
- R12: Address arithmetic wraps modulo 2^24 in both directions, and the carry out of bit 23 is discarded.
- R13: `addr_valid` is high exactly in the cycle after a request with mode 0 to 4. With no request, `addr_buf` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address request this cycle |
| mode | input | 3 | Addressing mode (0 imm, 1 direct, 2 indexed, 3 pre-inc, 4 post-inc) |
| src_is_ptr | input | 1 | Base is a pointer (1) or `gpr_val` (0) |
| ptr_idx | input | 2 | Pointer used as base / write-back target |
| gpr_val | input | 16 | General register value used as base |
| ext_word | input | 16 | Extension word: literal or signed offset |
| word_acc | input | 1 | Request is a 16-bit word access |
| ptr_ld_lo | input | 1 | Load low word of pointer `ptr_ld_idx` |
| ptr_ld_hi | input | 1 | Load high byte of pointer `ptr_ld_idx` |
| ptr_ld_idx | input | 2 | Pointer targeted by the load port |
| ptr_ld_data | input | 16 | Load data (high byte uses bits 7:0) |
| addr_buf | output | 24 | Address buffer register |
| addr_valid | output | 1 | Buffer updated by last cycle's request |
| misalign | output | 1 | Odd address on a word access |
| ptr_q | output | 96 | All four pointers, pointer i at bits 24i+23:24i |

## Verification
On every cycle the assertions check four things. `misalign` is only raised together with a valid, odd buffer on a word access. The valid strobe tracks requests and drops for reserved modes. A general register base in the increment modes leaves the pointers untouched. A post-increment returns the old pointer value. Indexed sums on general register bases and low-word loads are checked against the port values from one cycle earlier. Only the bench's scenarios can show three further behaviours: the load-over-write-back merge per half, carry and borrow wrap across bit 23, and pointer sequences over many successive stack-style pushes and pops.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int AGU_AW   = 24;
  localparam int AGU_DW   = 16;
  localparam int AGU_NPTR = 4;

  typedef enum logic [2:0] {
    MODE_IMM  = 3'd0,
    MODE_DIR  = 3'd1,
    MODE_IDX  = 3'd2,
    MODE_PRE  = 3'd3,
    MODE_POST = 3'd4
  } agu_mode_t;
endpackage

// File: rtl/agu_cla.sv
// Block carry look-ahead adder: generate/propagate per group, group carries
// resolved by a look-ahead chain, sum bits formed inside each group.
module agu_cla #(
  parameter int W   = 24,
  parameter int GRP = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);
  localparam int NG = W / GRP;

  logic [W-1:0]  g, p;
  logic [NG:0]   gc;
  logic [NG-1:0] gg, gp;

  assign g = a & b;
  assign p = a ^ b;

  genvar k;
  for (k = 0; k < NG; k++) begin : g_grp
    logic [GRP-1:0] gl, pl;
    logic [GRP:0]   cl;
    logic           ggk, gpk;

    assign gl = g[k*GRP +: GRP];
    assign pl = p[k*GRP +: GRP];

    always_comb begin
      ggk = 1'b0;
      gpk = 1'b1;
      for (int i = 0; i < GRP; i++) begin
        ggk = gl[i] | (pl[i] & ggk);
        gpk = gpk & pl[i];
      end
    end
    assign gg[k] = ggk;
    assign gp[k] = gpk;

    always_comb begin
      cl[0] = gc[k];
      for (int i = 0; i < GRP; i++) cl[i+1] = gl[i] | (pl[i] & cl[i]);
    end
    assign sum[k*GRP +: GRP] = pl ^ cl[GRP-1:0];
  end

  always_comb begin
    gc[0] = 1'b0;
    for (int j = 0; j < NG; j++) gc[j+1] = gg[j] | (gp[j] & gc[j]);
  end
endmodule

// File: rtl/agu_ptr_bank.sv
// Pointer registers, each split into a low word and an upper part.
// Load port beats write-back, half by half.
module agu_ptr_bank #(
  parameter int NPTR = 4,
  parameter int AW   = 24,
  parameter int DW   = 16,
  parameter int IW   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld_lo,
  input  logic               ld_hi,
  input  logic [IW-1:0]      ld_idx,
  input  logic [DW-1:0]      ld_data,
  input  logic               wb_en,
  input  logic [IW-1:0]      wb_idx,
  input  logic [AW-1:0]      wb_val,
  output logic [NPTR*AW-1:0] ptr_flat
);
  localparam int HW = AW - DW;

  genvar i;
  for (i = 0; i < NPTR; i++) begin : g_ptr
    logic [DW-1:0] lo_q;
    logic [HW-1:0] hi_q;
    logic          ld_me, wb_me;

    assign ld_me = (ld_idx == IW'(i));
    assign wb_me = wb_en && (wb_idx == IW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (ld_lo && ld_me)   lo_q <= ld_data;
        else if (wb_me)       lo_q <= wb_val[DW-1:0];
        if (ld_hi && ld_me)   hi_q <= ld_data[HW-1:0];
        else if (wb_me)       hi_q <= wb_val[AW-1:DW];
      end
    end

    assign ptr_flat[i*AW +: AW] = {hi_q, lo_q};
  end
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit
  import agu_pkg::*;
#(
  parameter int AW   = AGU_AW,
  parameter int DW   = AGU_DW,
  parameter int NPTR = AGU_NPTR,
  localparam int IW  = $clog2(NPTR)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [2:0]         mode,
  input  logic               src_is_ptr,
  input  logic [IW-1:0]      ptr_idx,
  input  logic [DW-1:0]      gpr_val,
  input  logic [DW-1:0]      ext_word,
  input  logic               word_acc,
  input  logic               ptr_ld_lo,
  input  logic               ptr_ld_hi,
  input  logic [IW-1:0]      ptr_ld_idx,
  input  logic [DW-1:0]      ptr_ld_data,
  output logic [AW-1:0]      addr_buf,
  output logic               addr_valid,
  output logic               misalign,
  output logic [NPTR*AW-1:0] ptr_q
);
  localparam int HW = AW - DW;

  logic [AW-1:0] base, offset, sum, nxt;
  logic          known, chk, wb;

  assign base   = src_is_ptr ? ptr_q[ptr_idx*AW +: AW] : {{HW{1'b0}}, gpr_val};
  assign offset = {{HW{ext_word[DW-1]}}, ext_word};

  agu_cla #(.W(AW), .GRP(4)) u_add (
    .a   (base),
    .b   (offset),
    .sum (sum)
  );

  always_comb begin
    nxt   = base;
    known = 1'b1;
    chk   = 1'b1;
    wb    = 1'b0;
    case (mode)
      MODE_IMM:  begin nxt = offset; chk = 1'b0; end
      MODE_DIR:  nxt = base;
      MODE_IDX:  nxt = sum;
      MODE_PRE:  begin nxt = sum;  wb = src_is_ptr; end
      MODE_POST: begin nxt = base; wb = src_is_ptr; end
      default:   begin known = 1'b0; chk = 1'b0; end
    endcase
  end

  agu_ptr_bank #(.NPTR(NPTR), .AW(AW), .DW(DW), .IW(IW)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .ld_lo    (ptr_ld_lo),
    .ld_hi    (ptr_ld_hi),
    .ld_idx   (ptr_ld_idx),
    .ld_data  (ptr_ld_data),
    .wb_en    (req_valid && wb),
    .wb_idx   (ptr_idx),
    .wb_val   (sum),
    .ptr_flat (ptr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_buf   <= '0;
      addr_valid <= 1'b0;
      misalign   <= 1'b0;
    end else begin
      addr_valid <= req_valid && known;
      misalign   <= req_valid && known && chk && word_acc && nxt[0];
      if (req_valid && known) addr_buf <= nxt;
    end
  end
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int AW   = 24,
  parameter int DW   = 16,
  parameter int NPTR = 4,
  localparam int IW  = $clog2(NPTR)
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [2:0]         mode,
  input logic               src_is_ptr,
  input logic [IW-1:0]      ptr_idx,
  input logic [DW-1:0]      gpr_val,
  input logic [DW-1:0]      ext_word,
  input logic               word_acc,
  input logic               ptr_ld_lo,
  input logic               ptr_ld_hi,
  input logic [IW-1:0]      ptr_ld_idx,
  input logic [DW-1:0]      ptr_ld_data,
  input logic [AW-1:0]      addr_buf,
  input logic               addr_valid,
  input logic               misalign,
  input logic [NPTR*AW-1:0] ptr_q
);
  localparam int HW = AW - DW;

  assert_misalign_qual_R11: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (addr_valid && addr_buf[0] && $past(word_acc)));

  assert_valid_on_req_R13: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode <= 3'd4) |=> addr_valid);

  assert_valid_idle_R13: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!addr_valid && $stable(addr_buf)));

  assert_reserved_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode > 3'd4) |=> (!addr_valid && $stable(addr_buf)));

  assert_imm_no_misalign_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 3'd0) |=> !misalign);

  assert_gpr_no_wb_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !src_is_ptr && !ptr_ld_lo && !ptr_ld_hi) |=> $stable(ptr_q));

  assert_post_old_base_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 3'd4 && src_is_ptr) |=>
      (addr_buf == $past(ptr_q[ptr_idx*AW +: AW])));

  assert_idx_sum_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == 3'd2 && !src_is_ptr) |=>
      (addr_buf == AW'($past({{HW{1'b0}}, gpr_val}) +
                       $past({{HW{ext_word[DW-1]}}, ext_word}))));

  assert_load_lo_R2: assert property (@(posedge clk) disable iff (rst)
    (ptr_ld_lo && !req_valid) |=>
      (ptr_q[$past(ptr_ld_idx)*AW +: DW] == $past(ptr_ld_data)));
endmodule

bind addr_gen_unit agu_checker #(.AW(AW), .DW(DW), .NPTR(NPTR)) u_chk (.*);

// File: tb/tb_addr_gen_unit.sv
module tb_addr_gen_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        src_is_ptr = 1'b0;
  logic [1:0]  ptr_idx = 2'd0;
  logic [15:0] gpr_val = 16'h0;
  logic [15:0] ext_word = 16'h0;
  logic        word_acc = 1'b0;
  logic        ptr_ld_lo = 1'b0;
  logic        ptr_ld_hi = 1'b0;
  logic [1:0]  ptr_ld_idx = 2'd0;
  logic [15:0] ptr_ld_data = 16'h0;
  logic [23:0] addr_buf;
  logic        addr_valid;
  logic        misalign;
  logic [95:0] ptr_q;

  addr_gen_unit dut (.*);

  always #5 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit running = 1'b0;

  // reference model state
  logic [23:0] m_ptr [4];
  logic [23:0] m_buf = '0;
  bit          m_val = 1'b0;
  bit          m_mis = 1'b0;
  string       t_buf = "R1";
  string       t_ptr = "R1";

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) m_ptr[i] = '0;
      m_buf = '0; m_val = 1'b0; m_mis = 1'b0;
      t_buf = "R1"; t_ptr = "R1";
    end else begin
      logic [23:0] base, res, sumv;
      int raw, offs;
      bit known, chk, wbk;
      base  = src_is_ptr ? m_ptr[ptr_idx] : {8'h00, gpr_val};
      offs  = int'($signed(ext_word));
      raw   = int'(base) + offs;
      sumv  = 24'(raw);
      known = 1'b1; chk = 1'b1; wbk = 1'b0; res = base;
      t_ptr = "R2";
      case (mode)
        3'd0: begin res = 24'(offs); chk = 1'b0; t_buf = "R3"; end
        3'd1: begin res = base; t_buf = "R4"; end
        3'd2: begin res = sumv; t_buf = "R5"; end
        3'd3: begin res = sumv; wbk = src_is_ptr; t_buf = "R6"; t_ptr = src_is_ptr ? "R6" : "R8"; end
        3'd4: begin res = base; wbk = src_is_ptr; t_buf = "R7"; t_ptr = src_is_ptr ? "R7" : "R8"; end
        default: begin known = 1'b0; chk = 1'b0; t_buf = "R10"; t_ptr = "R10"; end
      endcase
      if (!req_valid) begin known = 1'b0; chk = 1'b0; wbk = 1'b0; t_buf = "R13"; t_ptr = "R2"; end
      if (req_valid && known && mode != 3'd0 && (raw < 0 || raw > 24'hFFFFFF)) t_buf = "R12";
      m_val = known;
      m_mis = known && chk && word_acc && res[0];
      if (known) m_buf = res;
      if (wbk) m_ptr[ptr_idx] = sumv;
      if (wbk && (ptr_ld_lo || ptr_ld_hi) && ptr_ld_idx == ptr_idx) t_ptr = "R9";
      if (ptr_ld_lo) m_ptr[ptr_ld_idx][15:0]  = ptr_ld_data;
      if (ptr_ld_hi) m_ptr[ptr_ld_idx][23:16] = ptr_ld_data[7:0];
    end
  end

  always @(negedge clk) begin
    if (running) begin
      vectors++;
      if (addr_buf !== m_buf) begin
        errors++;
        $display("FAIL %s addr_buf actual=%h expected=%h", t_buf, addr_buf, m_buf);
      end
      if (addr_valid !== m_val) begin
        errors++;
        $display("FAIL R13 addr_valid actual=%b expected=%b (%s)", addr_valid, m_val, t_buf);
      end
      if (misalign !== m_mis) begin
        errors++;
        $display("FAIL R11 misalign actual=%b expected=%b", misalign, m_mis);
      end
      for (int i = 0; i < 4; i++) begin
        if (ptr_q[24*i +: 24] !== m_ptr[i]) begin
          errors++;
          $display("FAIL %s ptr%0d actual=%h expected=%h", t_ptr, i, ptr_q[24*i +: 24], m_ptr[i]);
        end
      end
    end
  end

  task automatic drive(input bit rv, input int md, input bit sp, input int pi,
                       input int g, input int e, input bit wa,
                       input bit ll, input bit lh, input int li, input int ld);
    @(negedge clk); #1;
    req_valid = rv; mode = 3'(md); src_is_ptr = sp; ptr_idx = 2'(pi);
    gpr_val = 16'(g); ext_word = 16'(e); word_acc = wa;
    ptr_ld_lo = ll; ptr_ld_hi = lh; ptr_ld_idx = 2'(li); ptr_ld_data = 16'(ld);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic load_ptr(input int idx, input int val);
    drive(0, 0, 0, 0, 0, 0, 0, 1, 1, idx, val & 16'hFFFF);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, idx, (val >> 16) & 8'hFF);
  endtask

  bit done = 1'b0;

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    running = 1'b1;
    repeat (3) @(negedge clk);              // R1: reset state compared
    #1 rst = 1'b0;
    idle(); idle();
    // R2: independent halves
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 16'hBEEF);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 16'hFF12);
    drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 16'h1000);
    load_ptr(0, 24'h000100); load_ptr(2, 24'h7FFFFE); load_ptr(3, 24'hFFFFFE);
    // R3 immediate, positive and negative literal, word access ignored
    drive(1, 0, 1, 0, 0, 16'h0123, 1, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 16'h8001, 1, 0, 0, 0, 0);
    // R4 direct: pointer and GPR base, offset ignored
    drive(1, 1, 1, 1, 0, 16'h5555, 1, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 16'hF00D, 16'h7777, 0, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 16'h0033, 16'h0000, 1, 0, 0, 0, 0);   // R11 odd word
    drive(1, 1, 0, 0, 16'h0033, 16'h0000, 0, 0, 0, 0, 0);   // R11 byte: no flag
    // R5 indexed, negative offset
    drive(1, 2, 1, 0, 0, 16'hFFF0, 1, 0, 0, 0, 0);
    drive(1, 2, 0, 0, 16'h0010, 16'h0004, 1, 0, 0, 0, 0);
    // R12 wrap up and down
    drive(1, 2, 1, 3, 0, 16'h0004, 1, 0, 0, 0, 0);
    drive(1, 2, 0, 0, 16'h0000, 16'hFFFE, 1, 0, 0, 0, 0);
    // R6 pre-increment (stack push style) and R7 post-increment
    for (int i = 0; i < 4; i++) drive(1, 3, 1, 1, 0, 16'hFFFE, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) drive(1, 4, 1, 1, 0, 16'h0002, 1, 0, 0, 0, 0);
    drive(1, 4, 1, 0, 0, 16'h0002, 1, 0, 0, 0, 0);
    drive(1, 3, 1, 2, 0, 16'h0003, 1, 0, 0, 0, 0);          // R12 crosses into 0x80xxxx
    drive(1, 4, 1, 3, 0, 16'h0004, 1, 0, 0, 0, 0);          // R12 pointer wraps
    // R8 GPR base in increment modes
    drive(1, 3, 0, 1, 16'h4444, 16'h0010, 1, 0, 0, 0, 0);
    drive(1, 4, 0, 2, 16'h4445, 16'h0010, 1, 0, 0, 0, 0);
    // R10 reserved modes
    drive(1, 5, 1, 1, 0, 16'h0010, 1, 0, 0, 0, 0);
    drive(1, 6, 1, 2, 0, 16'h0010, 1, 0, 0, 0, 0);
    drive(1, 7, 0, 0, 16'h0001, 16'h0010, 1, 0, 0, 0, 0);
    idle();
    // R9 load vs write-back on same pointer
    drive(1, 3, 1, 1, 0, 16'h0100, 1, 1, 0, 1, 16'hAAAA);
    drive(1, 4, 1, 1, 0, 16'hF000, 1, 0, 1, 1, 16'h0055);
    drive(1, 3, 1, 2, 0, 16'h0002, 1, 1, 0, 0, 16'h1234);   // different pointer
    idle();
    // mixed sequences
    for (int n = 0; n < 600; n++) begin
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 7), $urandom_range(0, 1),
            $urandom_range(0, 3), $urandom, $urandom, $urandom_range(0, 1),
            $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
            $urandom_range(0, 3), $urandom);
    end
    idle(); idle();
    // R1: reset in mid-run
    @(negedge clk); #1 rst = 1'b1;
    idle(); idle();
    @(negedge clk); #1 rst = 1'b0;
    idle(); idle();
    @(negedge clk);
    running = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule